// File: doc/BRIEF.md
# Crossing-Time Fault Signature Analyzer

The block receives two threshold-crossing streams for the high and the low threshold. One pair comes from a golden reference waveform and the other from the response of the circuit under test. Each stream is one bit per sample clock, and the comparators that produce them sit outside the block. On every sample the block tests whether the reference and the response agree on each threshold. It returns a registered fault bit that is high whenever either side disagrees.

The block also measures, for each reference period, how many samples each side disagreed. A rising edge of the reference high-threshold bit marks a period boundary. At each boundary after the first, the block latches the two widths and a coarse deviation class, and it pulses a done strobe for one cycle.

The class separates five cases:
- a response that matches within tolerance;
- a symmetric deviation (amplitude or phase);
- a deviation weighted to the high side (offset down or frequency up);
- a deviation weighted to the low side (offset up or frequency down);
- a response that never moves (stuck or DC output).

When the response never crosses one threshold, the whole period counts as mismatch on that side.

Top module: `xing_sig_analyzer`

## Requirements
- R1: After each clock edge, `fault_o` equals (`exp_hi` XOR `obs_hi`) OR (`exp_lo` XOR `obs_lo`) sampled at that edge. It is 0 in reset.
- R2: A boundary is a sample where `exp_hi` is 1 and the previous sample's `exp_hi` was 0. The first boundary after reset only opens a period. Every later boundary makes `done_o` high for exactly that one cycle and updates `hi_width`, `lo_width` and `fault_class`, which otherwise hold. All outputs are 0 in reset.
- R3: A period runs from a boundary sample up to, but not including, the next boundary sample. The raw high width is the number of its samples with `exp_hi`≠`obs_hi`. The raw low width is the same count for `exp_lo`≠`obs_lo`.
- R4: A side's observed bit has crossed if, on at least one sample of the period, it differs from the sample before it. If it never crossed, that side's reported width is the period length in samples.
- R5: Widths and period length saturate at 2^CNT_W−1 and never wrap.
- R6: If neither observed bit crossed during the period, `fault_class` is 4 (gross).
- R7: Otherwise, if both reported widths are ≤ `tol`, the class is 0 (pass). `tol` is sampled on the boundary sample.
- R8: Otherwise, if |high − low| ≤ `tol`, the class is 1 (amplitude or phase).
- R9: Otherwise, if high > low + `tol`, the class is 2 (offset down or frequency up).
- R10: Otherwise (low > high + `tol`), the class is 3 (offset up or frequency down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exp_hi | input | 1 | Reference stream, high threshold |
| obs_hi | input | 1 | Response stream, high threshold |
| exp_lo | input | 1 | Reference stream, low threshold |
| obs_lo | input | 1 | Response stream, low threshold |
| tol | input | CNT_W | Width tolerance in samples |
| fault_o | output | 1 | Registered per-sample disagreement bit |
| hi_width | output | CNT_W | Latched high-side width |
| lo_width | output | CNT_W | Latched low-side width |
| fault_class | output | 3 | Latched deviation class, 0 to 4 |
| done_o | output | 1 | One-cycle strobe when a period result is latched |

## Verification
The hardest cases to reach are the missing-crossing and gross classes. They need an observed bit that holds one value for an entire reference period, boundary sample included, with no edge against the last sample of the previous period. The stimulus reaches them with directed periods that hold the response at 0 after a period that also ended at 0, and with random periods that sometimes freeze one or both response bits.

Saturation needs periods longer than the counter range. A directed 300-sample period covers it, with a mostly mismatched high side and also with both sides frozen.

// File: rtl/xsa_pkg.sv
package xsa_pkg;
  typedef enum logic [2:0] {
    CLS_PASS   = 3'd0,
    CLS_AMPPH  = 3'd1,
    CLS_HIWIDE = 3'd2,
    CLS_LOWIDE = 3'd3,
    CLS_GROSS  = 3'd4
  } xsa_class_e;

  localparam int SIDES   = 2;
  localparam int SIDE_HI = 0;
  localparam int SIDE_LO = 1;
endpackage

// File: rtl/xsa_mismatch.sv
module xsa_mismatch
  import xsa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SIDES-1:0] exp_bits,
  input  logic [SIDES-1:0] obs_bits,
  output logic [SIDES-1:0] miss,
  output logic             fault_q
);
  // per-threshold disagreement, merged and registered
  assign miss = exp_bits ^ obs_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= |miss;
  end
endmodule

// File: rtl/xsa_sat_ctr.sv
module xsa_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         inc,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] base;
  logic [W-1:0] nxt;

  always_comb begin
    base = restart ? '0 : cnt_q;
    nxt  = (inc && (base != TOP)) ? base + 1'b1 : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt;
  end
endmodule

// File: rtl/xsa_side.sv
module xsa_side #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         miss,
  input  logic         obs,
  output logic [W-1:0] width_q,
  output logic         moved_q
);
  logic obs_d;
  logic moved_d;

  xsa_sat_ctr #(.W(W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .inc     (miss),
    .cnt_q   (width_q)
  );

  // a crossing is any change of the observed bit versus the prior sample
  always_comb moved_d = (restart ? 1'b0 : moved_q) | (obs ^ obs_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obs_d   <= 1'b0;
      moved_q <= 1'b0;
    end else begin
      obs_d   <= obs;
      moved_q <= moved_d;
    end
  end
endmodule

// File: rtl/xsa_classify.sv
module xsa_classify
  import xsa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] raw_hi,
  input  logic [W-1:0] raw_lo,
  input  logic [W-1:0] per_len,
  input  logic         moved_hi,
  input  logic         moved_lo,
  input  logic [W-1:0] tol,
  output logic [W-1:0] eff_hi,
  output logic [W-1:0] eff_lo,
  output xsa_class_e   cls
);
  logic [W:0] hi_x, lo_x, tol_x;

  always_comb begin
    eff_hi = moved_hi ? raw_hi : per_len;
    eff_lo = moved_lo ? raw_lo : per_len;
    hi_x   = {1'b0, eff_hi};
    lo_x   = {1'b0, eff_lo};
    tol_x  = {1'b0, tol};
    if (!moved_hi && !moved_lo)                 cls = CLS_GROSS;
    else if ((eff_hi <= tol) && (eff_lo <= tol)) cls = CLS_PASS;
    else if (hi_x > lo_x + tol_x)               cls = CLS_HIWIDE;
    else if (lo_x > hi_x + tol_x)               cls = CLS_LOWIDE;
    else                                        cls = CLS_AMPPH;
  end
endmodule

// File: rtl/xing_sig_analyzer.sv
module xing_sig_analyzer
  import xsa_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exp_hi,
  input  logic             obs_hi,
  input  logic             exp_lo,
  input  logic             obs_lo,
  input  logic [CNT_W-1:0] tol,
  output logic             fault_o,
  output logic [CNT_W-1:0] hi_width,
  output logic [CNT_W-1:0] lo_width,
  output logic [2:0]       fault_class,
  output logic             done_o
);
  logic [SIDES-1:0] exp_bits, obs_bits, miss, moved;
  logic [CNT_W-1:0] raw_w [SIDES];
  logic [CNT_W-1:0] per_len, eff_hi, eff_lo;
  logic             exp_hi_d, armed, bnd;
  xsa_class_e       cls;

  assign exp_bits = {exp_lo, exp_hi};
  assign obs_bits = {obs_lo, obs_hi};
  assign bnd      = exp_hi & ~exp_hi_d;

  xsa_mismatch u_mm (
    .clk      (clk),
    .rst_n    (rst_n),
    .exp_bits (exp_bits),
    .obs_bits (obs_bits),
    .miss     (miss),
    .fault_q  (fault_o)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    xsa_side #(.W(CNT_W)) u_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (bnd),
      .miss    (miss[s]),
      .obs     (obs_bits[s]),
      .width_q (raw_w[s]),
      .moved_q (moved[s])
    );
  end

  xsa_sat_ctr #(.W(CNT_W)) u_per (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (bnd),
    .inc     (1'b1),
    .cnt_q   (per_len)
  );

  xsa_classify #(.W(CNT_W)) u_cls (
    .raw_hi   (raw_w[SIDE_HI]),
    .raw_lo   (raw_w[SIDE_LO]),
    .per_len  (per_len),
    .moved_hi (moved[SIDE_HI]),
    .moved_lo (moved[SIDE_LO]),
    .tol      (tol),
    .eff_hi   (eff_hi),
    .eff_lo   (eff_lo),
    .cls      (cls)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_hi_d    <= 1'b0;
      armed       <= 1'b0;
      done_o      <= 1'b0;
      hi_width    <= '0;
      lo_width    <= '0;
      fault_class <= CLS_PASS;
    end else begin
      exp_hi_d <= exp_hi;
      done_o   <= bnd & armed;
      if (bnd) armed <= 1'b1;
      if (bnd && armed) begin
        hi_width    <= eff_hi;
        lo_width    <= eff_lo;
        fault_class <= cls;
      end
    end
  end
endmodule

// File: rtl/xsa_chk.sv
module xsa_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exp_hi,
  input logic             obs_hi,
  input logic             exp_lo,
  input logic             obs_lo,
  input logic [CNT_W-1:0] tol,
  input logic             fault_o,
  input logic [CNT_W-1:0] hi_width,
  input logic [CNT_W-1:0] lo_width,
  input logic [2:0]       fault_class,
  input logic             done_o
);
  // R1
  fault_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fault_o == ($past(exp_hi ^ obs_hi) | $past(exp_lo ^ obs_lo)));
  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R2
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(exp_hi) && !$past(exp_hi, 2)));
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(hi_width) && $stable(lo_width) && $stable(fault_class)));
  // R6
  class_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> fault_class <= 3'd4);
  // R7
  pass_within_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_class == 3'd0) |-> (hi_width <= $past(tol) && lo_width <= $past(tol)));
  // R8
  ampph_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_class == 3'd1) |->
      ({1'b0, hi_width} <= {1'b0, lo_width} + {1'b0, $past(tol)} &&
       {1'b0, lo_width} <= {1'b0, hi_width} + {1'b0, $past(tol)}));
  // R9
  hiwide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_class == 3'd2) |-> ({1'b0, hi_width} > {1'b0, lo_width} + {1'b0, $past(tol)}));
  // R10
  lowide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_class == 3'd3) |-> ({1'b0, lo_width} > {1'b0, hi_width} + {1'b0, $past(tol)}));
endmodule

bind xing_sig_analyzer xsa_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .exp_hi      (exp_hi),
  .obs_hi      (obs_hi),
  .exp_lo      (exp_lo),
  .obs_lo      (obs_lo),
  .tol         (tol),
  .fault_o     (fault_o),
  .hi_width    (hi_width),
  .lo_width    (lo_width),
  .fault_class (fault_class),
  .done_o      (done_o)
);

// File: tb/sim_xing_sig_analyzer.sv
`timescale 1ns/1ps
module sim_xing_sig_analyzer;
  localparam int CNT_W = 8;
  localparam int SAT   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exp_hi = 0, obs_hi = 0, exp_lo = 0, obs_lo = 0;
  logic [CNT_W-1:0] tol = '0;
  logic fault_o, done_o;
  logic [CNT_W-1:0] hi_width, lo_width;
  logic [2:0] fault_class;

  always #2 clk = ~clk;

  xing_sig_analyzer #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .exp_hi(exp_hi), .obs_hi(obs_hi),
    .exp_lo(exp_lo), .obs_lo(obs_lo), .tol(tol), .fault_o(fault_o),
    .hi_width(hi_width), .lo_width(lo_width), .fault_class(fault_class),
    .done_o(done_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model state
  bit m_peh = 0, m_poh = 0, m_pol = 0, m_armed = 0, m_sh = 0, m_sl = 0;
  int m_hc = 0, m_lc = 0, m_pc = 0;
  int e_hw = 0, e_lw = 0, e_cls = 0;
  string t_hw = "R2 reset high width", t_lw = "R2 reset low width", t_cls = "R2 reset class";

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v > SAT) ? SAT : v;
  endfunction

  function automatic int classify(int wh, int wl, bit sh, bit sl, int t);
    if (!sh && !sl) return 4;             // R6
    if (wh <= t && wl <= t) return 0;     // R7
    if (wh > wl + t) return 2;            // R9
    if (wl > wh + t) return 3;            // R10
    return 1;                             // R8
  endfunction

  function automatic string wtag(string side, bit moved, int w);
    if (w == SAT) return {"R5 saturated ", side, " width"};
    if (!moved)   return {"R4 missing-crossing ", side, " width"};
    return {"R3 ", side, " width"};
  endfunction

  task automatic step(bit eh, bit oh, bit el, bit ol, int t);
    bit bnd;
    int wh, wl, ef;
    @(negedge clk);
    exp_hi = eh; obs_hi = oh; exp_lo = el; obs_lo = ol; tol = t[CNT_W-1:0];
    @(posedge clk);
    #1;
    ef = int'((eh ^ oh) | (el ^ ol));
    chk(fault_o == ef[0], "R1 fault bit", fault_o, ef);
    bnd = eh && !m_peh;
    if (bnd && m_armed) begin
      wh = m_sh ? m_hc : m_pc;
      wl = m_sl ? m_lc : m_pc;
      e_hw = wh; e_lw = wl;
      e_cls = classify(wh, wl, m_sh, m_sl, t);
      t_hw = wtag("high", m_sh, wh);
      t_lw = wtag("low", m_sl, wl);
      case (e_cls)
        0: t_cls = "R7 pass class";
        1: t_cls = "R8 amplitude/phase class";
        2: t_cls = "R9 high-wide class";
        3: t_cls = "R10 low-wide class";
        default: t_cls = "R6 gross class";
      endcase
    end
    chk(done_o == (bnd && m_armed), "R2 done strobe", done_o, int'(bnd && m_armed));
    chk(hi_width == e_hw, t_hw, hi_width, e_hw);
    chk(lo_width == e_lw, t_lw, lo_width, e_lw);
    chk(fault_class == e_cls, t_cls, fault_class, e_cls);
    if (bnd) begin
      m_hc = 0; m_lc = 0; m_pc = 0; m_sh = 0; m_sl = 0;
    end
    m_hc = sat(m_hc + int'(eh ^ oh));
    m_lc = sat(m_lc + int'(el ^ ol));
    m_pc = sat(m_pc + 1);
    m_sh = m_sh | (oh ^ m_poh);
    m_sl = m_sl | (ol ^ m_pol);
    m_armed = m_armed | bnd;
    m_peh = eh; m_poh = oh; m_pol = ol;
  endtask

  // one reference period; sh/sl >= 0 freezes the observed bit at that value
  task automatic run_period(int p, int hl, int lon, int loff, int ohon, int ohoff,
                            int olon, int oloff, int sh, int sl, int t);
    for (int i = 0; i < p; i++) begin
      bit eh, el, oh, ol;
      eh = (i < hl);
      el = (i >= lon) && (i < loff);
      oh = (sh >= 0) ? sh[0] : ((i >= ohon) && (i < ohoff));
      ol = (sl >= 0) ? sl[0] : ((i >= olon) && (i < oloff));
      step(eh, oh, el, ol, t);
    end
  endtask

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R2 reset state
    chk(fault_o == 1'b0, "R2 reset fault bit", fault_o, 0);
    chk(done_o == 1'b0, "R2 reset done", done_o, 0);
    chk(hi_width == 0 && lo_width == 0, "R2 reset widths", hi_width, 0);
    chk(fault_class == 0, "R2 reset class", fault_class, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // arming period then directed cases; each result appears at the next boundary
    run_period(20, 6, 10, 16, 0, 6, 10, 16, -1, -1, 1);   // match, R7
    run_period(20, 6, 10, 16, 0, 6, 10, 16, -1, -1, 1);   // R7 pass
    run_period(20, 6, 10, 16, 1, 5, 11, 15, -1, -1, 0);   // R8 symmetric
    run_period(20, 6, 10, 16, 3, 6,  9, 16, -1, -1, 0);   // R9 high wider
    run_period(20, 6, 10, 16, 0, 7,  13, 16, -1, -1, 0);  // R10 low wider
    run_period(20, 6, 10, 16, 0, 0, 10, 16,  0, -1, 1);   // R4 high missing
    run_period(20, 6, 10, 16, 0, 0,  0,  0,  0,  0, 1);   // R6 gross
    run_period(20, 6, 10, 16, 0, 6, 10, 16, -1, -1, 2);   // R3 back to match
    run_period(300, 280, 285, 295, 0, 1, 285, 295, -1, -1, 3); // R5 saturating width
    run_period(300, 280, 285, 295, 0, 0, 0, 0, 0, 0, 3);   // R5 R6 frozen long
    run_period(20, 6, 10, 16, 0, 6, 10, 16, -1, -1, 1);

    // constrained random periods
    for (int k = 0; k < 150; k++) begin
      int p, hl, lon, loff, sh, sl, r;
      p    = $urandom_range(40, 8);
      hl   = $urandom_range(p / 2, 2);
      lon  = p / 2 + 1;
      loff = $urandom_range(p - 1, lon + 1);
      r    = $urandom_range(9, 0);
      sh   = (r == 0) ? 0 : ((r == 1) ? 1 : -1);
      r    = $urandom_range(9, 0);
      sl   = (r == 0) ? 0 : ((r == 1) ? 1 : -1);
      run_period(p, hl, lon, loff,
                 clampi($urandom_range(3, 0) - 1, 0, p - 1),
                 clampi(hl + $urandom_range(6, 0) - 3, 0, p - 1),
                 clampi(lon + $urandom_range(6, 0) - 3, 0, p - 1),
                 clampi(loff + $urandom_range(6, 0) - 3, 0, p - 1),
                 sh, sl, $urandom_range(3, 0));
    end
    run_period(20, 6, 10, 16, 0, 6, 10, 16, -1, -1, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule